// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register front end of a multi-timer event timer. It takes one access per cycle on a 64-bit register space, 4 or 8 bytes wide, and serves it in one of two ways. Registers it owns are read or written locally: a fixed capabilities word, a general configuration word holding the counter enable, and a 32-bit main counter that software may write. Accesses that fall in a timer's slot are steered to that timer over a shared per-timer port: a one-hot write strobe, a sub-register code, lane-steered data and mask, and a read return bus that the timer drives for the sub-register selected.

The main counter advances by one on each cycle where the tick-enable input is high while the enable bit is set. It holds its value while disabled and resumes from there. An interrupt status word is assembled from the timers' status inputs and can be cleared by write-one pulses. Accesses that are badly sized or misaligned are dropped without trace. Reads of such addresses, and of unmapped addresses, return zero.

Top module: `evt_timer_frontend`

## Requirements
- R1: Only request sizes 4 and 8 (bytes, on `req_size`) are accepted; any other size makes a write have no effect on any register or strobe, and makes a read return zero.
- R2: An access whose address is not a multiple of its size is dropped on write (no register change, no strobe) and returns zero on read.
- R3: A 4-byte access with address bit 2 set addresses bits 63:32 of the register: a write changes only those bits, and a read returns them in bits 31:0. Every 4-byte read returns zero in bits 63:32.
- R4: The capabilities register at offset 0x000 reads revision 1 in bits 7:0, NUM_TIMERS-1 in bits 12:8, zero in bits 15:13, 0x8086 in bits 31:16 and the tick period 100000000 in bits 63:32; writes to it have no effect.
- R5: The configuration register at offset 0x010 keeps only bit 0 (counter enable); every other bit, the legacy routing bit 1 included, reads zero after any write.
- R6: While the enable bit is set, the main counter increments by one, modulo 2^32, on each clock where `tick_en` is high; while it is clear, the counter holds its value, and counting resumes from that value when the bit is set again. An enable write takes effect from the next cycle.
- R7: The main counter at offset 0x0F0 reads zero-extended to 64 bits; a write replaces the addressed lanes of that 64-bit view and keeps the low 32 bits, and a counter write in the same cycle as a tick takes the written value.
- R8: Timer n owns offsets 0x100+0x20*n (configuration, code 0 on `tmr_reg`), +0x08 (comparator, code 1) and +0x10 (message route, code 2); a valid write there pulses bit n of `tmr_wr` alone with lane-steered `tmr_wdata`/`tmr_wmask`, and a read returns the 64-bit word on slice n of `tmr_rdata`.
- R9: The interrupt status register at offset 0x020 reads `irq_status` in its low NUM_TIMERS bits; a write pulses `irq_clr` with the written ones (after lane steering) that are also set in `irq_status`.
- R10: A read of an address mapping to no register (including offset +0x18 in a timer slot and anything beyond the last slot) returns zero, and a write there has no effect and raises no strobe.
- R11: After reset the counter is zero, the enable bit is clear, no read result is pending and no strobe is raised.
- R12: A read request accepted in cycle k yields `rd_valid` high in cycle k+1 with `rd_data` holding the value the register had in cycle k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick enable, one per count |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register space |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Read result |
| count_en | output | 1 | Counter enable bit |
| count_val | output | 32 | Main counter value |
| irq_status | input | NUM_TIMERS | Per-timer interrupt status |
| irq_clr | output | NUM_TIMERS | Per-timer status clear pulses |
| tmr_wr | output | NUM_TIMERS | One-hot timer write strobe |
| tmr_reg | output | 2 | Timer sub-register code |
| tmr_wmask | output | 64 | Lane mask of a timer write |
| tmr_wdata | output | 64 | Lane-steered timer write data |
| tmr_rdata | input | 64*NUM_TIMERS | Per-timer read data for the selected sub-register |

## Verification
The bench builds the block with NUM_TIMERS = 8 and ADDR_W = 12, so the capability count field reads 7, the last timer slot sits at 0x1E0 and the first address past all slots, 0x200, lies inside the decoded space and can be probed as unmapped. A behavioural model of the counter, enable and read return runs beside the design and is compared on every clock while the tick pattern changes between every cycle, every third cycle and none, which brings the 32-bit wrap, the frozen counter and write-versus-tick collisions within reach.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Register offsets that software and the timers rely on
  localparam int OFS_CAP    = 'h000;
  localparam int OFS_CFG    = 'h010;
  localparam int OFS_ISR    = 'h020;
  localparam int OFS_CNT    = 'h0F0;
  localparam int TMR_BASE   = 'h100;
  localparam int TMR_STRIDE = 'h20;
  localparam int TMR_SHIFT  = $clog2(TMR_STRIDE);

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CAP,
    TGT_CFG,
    TGT_ISR,
    TGT_CNT,
    TGT_TMR
  } tgt_e;

  typedef enum logic [1:0] {
    TREG_CFG   = 2'd0,
    TREG_CMP   = 2'd1,
    TREG_ROUTE = 2'd2,
    TREG_NONE  = 2'd3
  } treg_e;

endpackage

// File: rtl/evt_access_decode.sv
module evt_access_decode
  import evt_pkg::*;
#(
  parameter int NUM_TIMERS = 8,
  parameter int ADDR_W     = 12
) (
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [3:0]            req_size,
  input  logic [63:0]           req_wdata,
  output logic                  acc_ok,
  output logic                  narrow,
  output logic                  hi_lane,
  output tgt_e                  tgt,
  output logic [NUM_TIMERS-1:0] tmr_hit,
  output treg_e                 treg,
  output logic [63:0]           lane_mask,
  output logic [63:0]           lane_data
);

  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFS_CAP);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFS_ISR);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);

  logic                  size_ok;
  logic                  align_ok;
  logic [ADDR_W-1:0]     word;
  logic [NUM_TIMERS-1:0] slot_hit;

  always_comb begin
    narrow   = (req_size == 4'd4);
    size_ok  = narrow || (req_size == 4'd8);
    align_ok = narrow ? (req_addr[1:0] == 2'b00) : (req_addr[2:0] == 3'b000);
    acc_ok   = req_valid && size_ok && align_ok;
    hi_lane  = narrow && req_addr[2];
    word     = {req_addr[ADDR_W-1:3], 3'b000};
  end

  // Sub-register inside a timer slot: 8-byte words 0..2 used, 3 unmapped
  always_comb begin
    case (word[TMR_SHIFT-1:3])
      2'd0:    treg = TREG_CFG;
      2'd1:    treg = TREG_CMP;
      2'd2:    treg = TREG_ROUTE;
      default: treg = TREG_NONE;
    endcase
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_BASE = ADDR_W'(TMR_BASE + TMR_STRIDE * i);
    assign slot_hit[i] = (word[ADDR_W-1:TMR_SHIFT] == SLOT_BASE[ADDR_W-1:TMR_SHIFT]);
  end

  assign tmr_hit = (acc_ok && (treg != TREG_NONE)) ? slot_hit : '0;

  always_comb begin
    tgt = TGT_NONE;
    if (acc_ok) begin
      if (word == A_CAP)      tgt = TGT_CAP;
      else if (word == A_CFG) tgt = TGT_CFG;
      else if (word == A_ISR) tgt = TGT_ISR;
      else if (word == A_CNT) tgt = TGT_CNT;
      else if (|tmr_hit)      tgt = TGT_TMR;
    end
  end

  // Half-word lane steering of write data
  always_comb begin
    if (!narrow) begin
      lane_mask = '1;
      lane_data = req_wdata;
    end else if (hi_lane) begin
      lane_mask = {32'hFFFF_FFFF, 32'h0};
      lane_data = {req_wdata[31:0], 32'h0};
    end else begin
      lane_mask = {32'h0, 32'hFFFF_FFFF};
      lane_data = {32'h0, req_wdata[31:0]};
    end
  end

  always_comb begin
    AST_SLOT_ONEHOT: assert ($onehot0(tmr_hit)); // R8
    if (!acc_ok) begin
      AST_BAD_NO_TARGET: assert ((tmr_hit == '0) && (tgt == TGT_NONE)); // R2
    end
  end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cfg_wr,
  input  logic        cnt_wr,
  input  logic [31:0] wr_mask,
  input  logic [31:0] wr_data,
  output logic        cfg_en,
  output logic [31:0] count
);

  logic        en_nxt;
  logic        en_ce;
  logic [31:0] cnt_nxt;
  logic        cnt_ce;

  always_comb begin
    en_ce  = cfg_wr && wr_mask[0];
    en_nxt = wr_data[0];
  end

  // A write of the counter wins over a tick in the same cycle
  always_comb begin
    cnt_ce = cnt_wr || (cfg_en && tick_en);
    if (cnt_wr) cnt_nxt = (count & ~wr_mask) | (wr_data & wr_mask);
    else        cnt_nxt = count + 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_en <= 1'b0;
    else if (en_ce) cfg_en <= en_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= 32'd0;
    else if (cnt_ce) count <= cnt_nxt;
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cnt_wr) |=> $stable(count)); // R6

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && tick_en && !cnt_wr) |=> (count == $past(count) + 32'd1)); // R6

endmodule

// File: rtl/evt_read_port.sv
module evt_read_port
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 8,
  parameter logic [63:0] CAP_VALUE  = 64'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_fire,
  input  logic                     acc_ok,
  input  logic                     narrow,
  input  logic                     hi_lane,
  input  tgt_e                     tgt,
  input  logic [NUM_TIMERS-1:0]    tmr_hit,
  input  logic                     cfg_en,
  input  logic [31:0]              count,
  input  logic [NUM_TIMERS-1:0]    irq_status,
  input  logic [64*NUM_TIMERS-1:0] tmr_rdata,
  output logic                     rd_valid,
  output logic [63:0]              rd_data
);

  logic [63:0] tmr_word;
  logic [63:0] sel_word;
  logic [63:0] ret_word;

  always_comb begin
    tmr_word = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (tmr_hit[i]) tmr_word = tmr_word | tmr_rdata[i*64 +: 64];
    end
  end

  always_comb begin
    case (tgt)
      TGT_CAP: sel_word = CAP_VALUE;
      TGT_CFG: sel_word = {63'h0, cfg_en};
      TGT_ISR: sel_word = 64'(irq_status);
      TGT_CNT: sel_word = {32'h0, count};
      TGT_TMR: sel_word = tmr_word;
      default: sel_word = '0;
    endcase
  end

  always_comb begin
    if (!narrow)      ret_word = sel_word;
    else if (hi_lane) ret_word = {32'h0, sel_word[63:32]};
    else              ret_word = {32'h0, sel_word[31:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= ret_word;
  end

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid); // R12

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !acc_ok) |=> (rd_data == 64'h0)); // R1

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && narrow) |=> (rd_data[63:32] == 32'h0)); // R3

endmodule

// File: rtl/evt_timer_frontend.sv
module evt_timer_frontend
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 8,
  parameter int          ADDR_W     = 12,
  parameter logic [7:0]  REVISION   = 8'd1,
  parameter logic [15:0] VENDOR_ID  = 16'h8086,
  parameter logic [31:0] TICK_FS    = 32'd100_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [3:0]               req_size,
  input  logic [63:0]              req_wdata,
  output logic                     rd_valid,
  output logic [63:0]              rd_data,
  output logic                     count_en,
  output logic [31:0]              count_val,
  input  logic [NUM_TIMERS-1:0]    irq_status,
  output logic [NUM_TIMERS-1:0]    irq_clr,
  output logic [NUM_TIMERS-1:0]    tmr_wr,
  output logic [1:0]               tmr_reg,
  output logic [63:0]              tmr_wmask,
  output logic [63:0]              tmr_wdata,
  input  logic [64*NUM_TIMERS-1:0] tmr_rdata
);

  // Fixed capability word; bits 15:13 (counter size, spare, legacy) stay zero
  localparam logic [63:0] CAP_VALUE = {TICK_FS, VENDOR_ID, 3'b000,
                                       5'(NUM_TIMERS - 1), REVISION};

  logic                  acc_ok;
  logic                  narrow;
  logic                  hi_lane;
  tgt_e                  tgt;
  logic [NUM_TIMERS-1:0] tmr_hit;
  treg_e                 treg;
  logic [63:0]           lane_mask;
  logic [63:0]           lane_data;
  logic                  wr_ok;
  logic                  rd_fire;
  logic                  cfg_wr;
  logic                  cnt_wr;

  evt_access_decode #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .acc_ok    (acc_ok),
    .narrow    (narrow),
    .hi_lane   (hi_lane),
    .tgt       (tgt),
    .tmr_hit   (tmr_hit),
    .treg      (treg),
    .lane_mask (lane_mask),
    .lane_data (lane_data)
  );

  always_comb begin
    wr_ok   = acc_ok && req_write;
    rd_fire = req_valid && !req_write;
    cfg_wr  = wr_ok && (tgt == TGT_CFG);
    cnt_wr  = wr_ok && (tgt == TGT_CNT);
  end

  evt_main_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cfg_wr  (cfg_wr),
    .cnt_wr  (cnt_wr),
    .wr_mask (lane_mask[31:0]),
    .wr_data (lane_data[31:0]),
    .cfg_en  (count_en),
    .count   (count_val)
  );

  evt_read_port #(.NUM_TIMERS(NUM_TIMERS), .CAP_VALUE(CAP_VALUE)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .acc_ok     (acc_ok),
    .narrow     (narrow),
    .hi_lane    (hi_lane),
    .tgt        (tgt),
    .tmr_hit    (tmr_hit),
    .cfg_en     (count_en),
    .count      (count_val),
    .irq_status (irq_status),
    .tmr_rdata  (tmr_rdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  always_comb begin
    tmr_wr    = wr_ok ? tmr_hit : '0;
    tmr_reg   = treg;
    tmr_wmask = lane_mask;
    tmr_wdata = lane_data;
    if (wr_ok && (tgt == TGT_ISR))
      irq_clr = lane_data[NUM_TIMERS-1:0] & lane_mask[NUM_TIMERS-1:0] & irq_status;
    else
      irq_clr = '0;
  end

  always_comb begin
    AST_CLEAR_ONLY_SET: assert ((irq_clr & ~irq_status) == '0); // R9
    AST_WRITE_ONE_TIMER: assert ($onehot0(tmr_wr)); // R8
  end

endmodule

// File: tb/sim_evt_timer_frontend.sv
`timescale 1ns/1ps
module sim_evt_timer_frontend;

  localparam int NT = 8;
  localparam int AW = 12;

  logic           clk;
  logic           rst_n;
  logic           tick_en;
  logic           req_valid;
  logic           req_write;
  logic [AW-1:0]  req_addr;
  logic [3:0]     req_size;
  logic [63:0]    req_wdata;
  logic           rd_valid;
  logic [63:0]    rd_data;
  logic           count_en;
  logic [31:0]    count_val;
  logic [NT-1:0]  irq_status;
  logic [NT-1:0]  irq_clr;
  logic [NT-1:0]  tmr_wr;
  logic [1:0]     tmr_reg;
  logic [63:0]    tmr_wmask;
  logic [63:0]    tmr_wdata;
  logic [64*NT-1:0] tmr_rdata;

  evt_timer_frontend #(.NUM_TIMERS(NT), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .count_en(count_en), .count_val(count_val),
    .irq_status(irq_status), .irq_clr(irq_clr),
    .tmr_wr(tmr_wr), .tmr_reg(tmr_reg), .tmr_wmask(tmr_wmask),
    .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycnt = 0;
  int tick_div = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_tag = "R11";

  function automatic logic [63:0] stub(int t, int r);
    return {32'hA000_0000 | 32'(t << 8) | 32'(r), 32'h5000_0000 | 32'(t << 4) | 32'(r)};
  endfunction

  // Timer stand-ins: return a word naming timer and sub-register
  always_comb begin
    for (int t = 0; t < NT; t++) tmr_rdata[t*64 +: 64] = stub(t, int'(tmr_reg));
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt;
  bit          m_en;
  bit          m_rv;
  logic [63:0] m_rd;
  string       m_tag;

  function automatic logic [63:0] m_word(int a);
    int t, r;
    if (a == 'h000) return {32'd100_000_000, 16'h8086, 3'b000, 5'(NT - 1), 8'd1};
    if (a == 'h010) return {63'h0, m_en};
    if (a == 'h020) return 64'(irq_status);
    if (a == 'h0F0) return {32'h0, m_cnt};
    if (a >= 'h100) begin
      t = (a - 'h100) / 32;
      r = ((a - 'h100) % 32) / 8;
      if (t < NT && r < 3) return stub(t, r);
    end
    return 64'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_rv = 0; m_rd = 0; m_tag = "R11";
    end else begin
      bit ok, hi, ne;
      int wa;
      logic [63:0] msk, dat, v, merged;
      logic [31:0] nc;
      ok = req_valid && (req_size == 4 || req_size == 8) &&
           ((int'(req_addr) % int'(req_size)) == 0);
      wa = int'(req_addr) & ~7;
      hi = (req_size == 4) && req_addr[2];
      m_rv = req_valid && !req_write;
      if (m_rv) begin
        v = ok ? m_word(wa) : 64'h0;
        if (req_size == 4) v = hi ? (v >> 32) : (v & 64'hFFFF_FFFF);
        m_rd = v;
        m_tag = cur_tag;
      end
      nc = m_cnt; ne = m_en;
      if (m_en && tick_en) nc = m_cnt + 1;
      if (ok && req_write) begin
        if (req_size == 8) begin msk = '1; dat = req_wdata; end
        else if (hi) begin msk = 64'hFFFF_FFFF_0000_0000; dat = {req_wdata[31:0], 32'h0}; end
        else begin msk = 64'h0000_0000_FFFF_FFFF; dat = {32'h0, req_wdata[31:0]}; end
        if (wa == 'h010 && msk[0]) ne = dat[0];
        if (wa == 'h0F0) begin
          merged = ({32'h0, m_cnt} & ~msk) | (dat & msk);
          nc = merged[31:0];
        end
      end
      m_cnt = nc; m_en = ne;
    end
  end

  // Compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      chk(count_val == m_cnt, "R6 counter", 64'(count_val), 64'(m_cnt));
      chk(count_en == m_en, "R5 enable", 64'(count_en), 64'(m_en));
      chk(rd_valid == m_rv, "R12 rd_valid", 64'(rd_valid), 64'(m_rv));
      if (m_rv) chk(rd_data == m_rd, m_tag, rd_data, m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_tick();
    cycnt++;
    tick_en = (tick_div == 0) ? 1'b0 : ((cycnt % tick_div) == 0);
  endtask

  task automatic acc(bit w, int a, int s, logic [63:0] d, string tag);
    @(negedge clk);
    set_tick();
    req_valid = 1'b1; req_write = w; req_addr = AW'(a);
    req_size = 4'(s); req_wdata = d; cur_tag = tag;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      set_tick();
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_en = 0; req_valid = 0; req_write = 0;
    req_addr = '0; req_size = 4'd8; req_wdata = '0; irq_status = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(count_val == 0, "R11 counter after reset", 64'(count_val), 0);
    chk(count_en == 0, "R11 enable after reset", 64'(count_en), 0);
    chk(rd_valid == 0, "R11 rd_valid after reset", 64'(rd_valid), 0);
    chk(tmr_wr == 0 && irq_clr == 0, "R11 strobes after reset", 64'(tmr_wr), 0);
    chk_on = 1;
    tick_div = 1;
    acc(0, 'h010, 8, 0, "R11 cfg read");
    idle(5);

    // Capabilities
    acc(0, 'h000, 8, 0, "R4 cap 8-byte");
    acc(0, 'h000, 4, 0, "R3 cap low word");
    acc(0, 'h004, 4, 0, "R3 cap high word");
    acc(1, 'h000, 8, 64'h0, "R4 cap write");
    acc(0, 'h000, 8, 0, "R4 cap after write");

    // Enable, all other config bits forced to zero
    acc(1, 'h010, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R5 cfg write");
    acc(0, 'h010, 8, 0, "R5 cfg only enable");
    idle(20);
    tick_div = 3;
    idle(20);
    acc(0, 'h0F0, 8, 0, "R7 counter 8-byte read");
    acc(1, 'h010, 4, 64'h0, "R6 disable");
    idle(15);
    acc(1, 'h014, 4, 64'hFFFF_FFFF, "R3 cfg high lane leaves enable");
    idle(10);
    acc(0, 'h0F0, 8, 0, "R6 frozen counter read");
    acc(1, 'h010, 4, 64'h3, "R6 resume");
    idle(12);

    // Counter writes and wrap
    tick_div = 1;
    acc(1, 'h0F0, 8, 64'hDEAD_BEEF_FFFF_FFF0, "R7 counter write keeps low 32");
    acc(0, 'h0F0, 8, 0, "R7 counter zero-extended");
    idle(25);
    acc(1, 'h0F4, 4, 64'h1234_5678, "R7 high-lane counter write");
    acc(0, 'h0F4, 4, 0, "R7 counter high word zero");
    acc(1, 'h0F0, 4, 64'h0000_0100, "R7 low-lane counter write beats tick");
    acc(0, 'h0F0, 4, 0, "R7 counter low word");
    idle(4);

    // Bad sizes and misalignment
    acc(1, 'h0F0, 2, 64'h0, "R1 size 2 write");
    chk(tmr_wr == 0, "R1 no strobe", 64'(tmr_wr), 0);
    acc(1, 'h0F0, 1, 64'h0, "R1 size 1 write");
    acc(1, 'h010, 16, 64'h0, "R1 size 16 write");
    acc(0, 'h000, 2, 0, "R1 size 2 read");
    acc(0, 'h0F0, 1, 0, "R1 size 1 read");
    acc(1, 'h0F4, 8, 64'h0, "R2 misaligned 8-byte write");
    acc(1, 'h012, 4, 64'h0, "R2 misaligned 4-byte write");
    acc(0, 'h0F4, 8, 0, "R2 misaligned 8-byte read");
    acc(0, 'h002, 4, 0, "R2 misaligned 4-byte read");
    acc(1, 'h10C, 8, 64'hFF, "R2 misaligned timer write");
    chk(tmr_wr == 0, "R2 no timer strobe", 64'(tmr_wr), 0);
    acc(1, 'h108, 2, 64'hFF, "R1 size 2 timer write");
    chk(tmr_wr == 0, "R1 no timer strobe", 64'(tmr_wr), 0);
    idle(3);

    // Timer slots
    tick_div = 0;
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 3; r++)
        acc(0, 'h100 + 32*t + 8*r, 8, 0, "R8 timer read");
    acc(0, 'h100 + 32*5 + 12, 4, 0, "R8 timer comparator high word");
    acc(0, 'h100 + 32*2 + 16, 4, 0, "R8 timer route low word");
    acc(1, 'h100 + 32*3 + 12, 4, 64'h1234_5678, "R8 comparator high write");
    chk(tmr_wr == 8'h08, "R8 strobe timer 3", 64'(tmr_wr), 64'h08);
    chk(tmr_reg == 2'd1, "R8 code comparator", 64'(tmr_reg), 1);
    chk(tmr_wmask == 64'hFFFF_FFFF_0000_0000, "R8 high mask", tmr_wmask, 64'hFFFF_FFFF_0000_0000);
    chk(tmr_wdata == 64'h1234_5678_0000_0000, "R8 high data", tmr_wdata, 64'h1234_5678_0000_0000);
    acc(1, 'h100 + 32*7 + 16, 8, 64'hCAFE_0000_0000_BEEF, "R8 route write");
    chk(tmr_wr == 8'h80, "R8 strobe timer 7", 64'(tmr_wr), 64'h80);
    chk(tmr_reg == 2'd2, "R8 code route", 64'(tmr_reg), 2);
    chk(tmr_wmask == '1, "R8 full mask", tmr_wmask, '1);
    chk(tmr_wdata == 64'hCAFE_0000_0000_BEEF, "R8 full data", tmr_wdata, 64'hCAFE_0000_0000_BEEF);
    acc(1, 'h100, 4, 64'hAB, "R8 config low write");
    chk(tmr_wr == 8'h01 && tmr_reg == 2'd0, "R8 strobe timer 0 config", 64'({tmr_reg, tmr_wr}), 64'h001);
    chk(tmr_wdata == 64'hAB && tmr_wmask == 64'hFFFF_FFFF, "R3 low lane data", tmr_wdata, 64'hAB);

    // Unmapped
    acc(1, 'h118, 8, 64'h1, "R10 slot gap write");
    chk(tmr_wr == 0, "R10 no strobe in gap", 64'(tmr_wr), 0);
    acc(1, 'h200, 8, 64'h1, "R10 past last slot write");
    chk(tmr_wr == 0, "R10 no strobe past slots", 64'(tmr_wr), 0);
    acc(0, 'h118, 8, 0, "R10 slot gap read");
    acc(0, 'h200, 8, 0, "R10 past last slot read");
    acc(0, 'h030, 4, 0, "R10 unmapped low read");

    // Interrupt status
    acc(0, 'h020, 8, 0, "R9 status read");
    acc(1, 'h020, 8, 64'hFF, "R9 status clear");
    chk(irq_clr == 8'h5A, "R9 clear pulses", 64'(irq_clr), 64'h5A);
    acc(1, 'h020, 4, 64'h0F, "R9 partial clear");
    chk(irq_clr == 8'h0A, "R9 partial clear pulses", 64'(irq_clr), 64'h0A);
    acc(1, 'h024, 4, 64'hFF, "R9 high-lane clear");
    chk(irq_clr == 8'h00, "R9 high lane clears nothing", 64'(irq_clr), 0);
    idle(1);
    chk(irq_clr == 8'h00, "R9 no pulse when idle", 64'(irq_clr), 0);
    irq_status = 8'hC3;
    acc(0, 'h020, 4, 0, "R9 status read new value");
    idle(4);

    done = 1;
    summary();
    $finish;
  end

endmodule